// File: doc/BRIEF.md
# Touch Converter Serial Command Front End

This block is the device-side digital front end of a four-channel serial touch-screen converter. While the chip select is low it watches the serial data input and waits for a start bit. It then collects an 8-bit control word and raises a busy flag for one serial clock. After that it shifts a conversion result out on the data output, most significant bit first. The result is 12 or 8 bits long, as the control word selects. The result itself arrives as a parallel word from the analog side and is captured at the moment the control word completes.

The control word also sets the channel select and reference-mode outputs that steer the analog multiplexer. Its two power bits drive the power-down state and the gating of the pen-interrupt enable. The serial clock, data input and chip select are synchronous inputs that the block samples with a faster system clock. Each phase of the serial clock must last at least two system clocks. A new control word may start while the previous result is still shifting out, so a 12-bit conversion can run every 16 serial clocks and an 8-bit one every 12.

Top module: `tsc_serial_frontend`

## Requirements
- R1: While waiting for a control word, low bits on `din` are ignored. The first high bit sampled on a rising `sclk` edge is the start bit and becomes bit 7 of the control word. The next seven rising edges supply bits 6 to 0.
- R2: The control word fields are: bits 6:4 are the channel (`chan_sel`), bit 3 is the short-result select (`res_short`, 1 gives 8 bits), bit 2 is the reference select (`ref_single`, 1 gives single-ended), and bits 1:0 are the power code. All outputs update when the word completes.
- R3: With `res_short` low, the 12 bits of the captured result appear on `dout` on the 12 falling edges that follow the busy cycle, MSB first. `dout` is low on the falling edges after that.
- R4: With `res_short` high, only the upper 8 bits of the captured result are shifted out, MSB first. `dout` is low afterwards.
- R5: `busy` rises on the first falling `sclk` edge after the eighth control bit and falls on the next falling edge. `dout` is low while `busy` is high.
- R6: `adc_data` is captured when the control word completes. Changes to it after that point do not alter the result being shifted out.
- R7: A new start bit may arrive 16 serial clocks after the previous one in 12-bit mode, or 12 in 8-bit mode. Both results then come out intact.
- R8: Power codes 00 and 01 hold `pwr_down` high whenever no conversion is in progress. Power codes 11 and 10 keep it low. `pwr_down` is low from the completion of a control word until the last result bit has been shifted.
- R9: `pen_irq_en` is high only with power code 00 while the block is powered down.
- R10: Power code 10 is treated as always powered and raises `pd_reserved`.
- R11: `diff_sw_on` is high during a conversion when the reference select is 0, and low at all other times.
- R12: Raising `cs_n` discards a partial control word, ends any busy cycle or readout, and drops `dout_en`.
- R13: After reset, `busy` and `dout_en` are low, `chan_sel` is 0, the power code is 00 (`pwr_down` and `pen_irq_en` are high), and `pd_reserved` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| adc_data | input | RES_W | Parallel conversion result from the analog side |
| dout | output | 1 | Serial result data |
| dout_en | output | 1 | Output enable for `dout` (low means high impedance) |
| busy | output | 1 | Conversion busy flag |
| chan_sel | output | 3 | Selected input channel |
| ref_single | output | 1 | 1 = single-ended reference, 0 = differential |
| diff_sw_on | output | 1 | Differential input switches closed during conversion |
| res_short | output | 1 | 1 = 8-bit result, 0 = 12-bit result |
| pwr_down | output | 1 | Converter in power-down state |
| pen_irq_en | output | 1 | Pen interrupt enabled |
| pd_reserved | output | 1 | Reserved power code 10 is in effect |

## Verification
The assertions check on every cycle the invariants that hold without reference to a frame. A completed control word always carries its start bit. `dout` stays quiet while `busy` is high. The readout counter stays in range. A pen interrupt is enabled only in the powered-down state, and a conversion in progress is never powered down. The switches stay open in single-ended mode. A high chip select clears the receiver, the transmitter and the output enable. The bench scenarios show the rest: the exact edge on which `busy` and each result bit appear, bit order and result length in both modes, capture of the result word, two overlapped frames, and a start bit that follows leading zeros.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int CMD_BITS = 8;
  localparam int CNT_W    = $clog2(CMD_BITS);

  // Field order matches the serial order of the control word, MSB first.
  typedef struct packed {
    logic       start;
    logic [2:0] chan;
    logic       short_res;
    logic       single_ref;
    logic [1:0] pwr_code;
  } ctrl_t;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARM   = 2'd1,
    TX_BUSY  = 2'd2,
    TX_SHIFT = 2'd3
  } tx_state_t;

endpackage

// File: rtl/tsc_cmd_rx.sv
module tsc_cmd_rx
  import tsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  rise,
  input  logic  din,
  output logic  cmd_valid,
  output ctrl_t cmd
);

  logic                active_q, active_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CMD_BITS-1:0] sh_q, sh_d;
  logic                valid_d;
  ctrl_t               cmd_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    valid_d  = 1'b0;
    cmd_d    = cmd;
    if (cs_n) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (rise) begin
      if (!active_q) begin
        // hunt for the start bit; zeros are dropped
        if (din) begin
          active_d = 1'b1;
          sh_d     = {{(CMD_BITS-1){1'b0}}, 1'b1};
          cnt_d    = CNT_W'(1);
        end
      end else begin
        sh_d = {sh_q[CMD_BITS-2:0], din};
        if (cnt_q == CNT_W'(CMD_BITS-1)) begin
          active_d = 1'b0;
          cnt_d    = '0;
          valid_d  = 1'b1;
          cmd_d    = ctrl_t'(sh_d);
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
    end else begin
      active_q  <= active_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      cmd_valid <= valid_d;
      cmd       <= cmd_d;
    end
  end

  // R1: every accepted word carries its start bit in the top position
  a_r1_start_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd.start);

  // R12: a high chip select leaves the receiver hunting from bit zero
  a_r12_rx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!active_q && cnt_q == '0));

endmodule

// File: rtl/tsc_result_tx.sv
module tsc_result_tx
  import tsc_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fall,
  input  logic             load,
  input  logic             short_res,
  input  logic [RES_W-1:0] adc_data,
  output logic             busy,
  output logic             dout,
  output logic             converting
);

  localparam int LEFT_W = $clog2(RES_W + 1);
  localparam int PAD_W  = RES_W - SHORT_W;

  tx_state_t          st_q, st_d;
  logic [RES_W-1:0]   sh_q, sh_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               len_short_q, len_short_d;
  logic               busy_d, dout_d;

  always_comb begin
    st_d        = st_q;
    sh_d        = sh_q;
    left_d      = left_q;
    len_short_d = len_short_q;
    busy_d      = busy;
    dout_d      = dout;
    if (cs_n) begin
      st_d   = TX_IDLE;
      busy_d = 1'b0;
      dout_d = 1'b0;
      left_d = '0;
    end else if (load) begin
      // capture the analog word now; short mode keeps the upper bits
      st_d        = TX_ARM;
      len_short_d = short_res;
      sh_d        = short_res ? {adc_data[RES_W-1 -: SHORT_W], {PAD_W{1'b0}}}
                              : adc_data;
    end else if (fall) begin
      unique case (st_q)
        TX_ARM: begin
          st_d   = TX_BUSY;
          busy_d = 1'b1;
          dout_d = 1'b0;
        end
        TX_BUSY: begin
          st_d   = TX_SHIFT;
          busy_d = 1'b0;
          dout_d = sh_q[RES_W-1];
          sh_d   = {sh_q[RES_W-2:0], 1'b0};
          left_d = len_short_q ? LEFT_W'(SHORT_W-1) : LEFT_W'(RES_W-1);
        end
        TX_SHIFT: begin
          if (left_q == '0) begin
            st_d   = TX_IDLE;
            dout_d = 1'b0;
          end else begin
            dout_d = sh_q[RES_W-1];
            sh_d   = {sh_q[RES_W-2:0], 1'b0};
            left_d = left_q - LEFT_W'(1);
          end
        end
        default: dout_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= TX_IDLE;
      sh_q        <= '0;
      left_q      <= '0;
      len_short_q <= 1'b0;
      busy        <= 1'b0;
      dout        <= 1'b0;
    end else begin
      st_q        <= st_d;
      sh_q        <= sh_d;
      left_q      <= left_d;
      len_short_q <= len_short_d;
      busy        <= busy_d;
      dout        <= dout_d;
    end
  end

  assign converting = load || (st_q != TX_IDLE);

  // R5: no data bit is driven during the busy cycle
  a_r5_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout);

  // R3: the bit counter never exceeds the long result length
  a_r3_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left_q < LEFT_W'(RES_W));

  // R12: a high chip select ends busy and any readout
  a_r12_tx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!busy && st_q == TX_IDLE));

endmodule

// File: rtl/tsc_power_ctl.sv
module tsc_power_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_code,
  input  logic       converting,
  output logic       pwr_down,
  output logic       pen_irq_en,
  output logic       pd_reserved
);

  logic sleeps_between;

  // codes 00 and 01 sleep between conversions; 10 and 11 stay powered
  assign sleeps_between = !pwr_code[1];
  assign pwr_down       = sleeps_between && !converting;
  assign pen_irq_en     = (pwr_code == 2'b00) && !converting;
  assign pd_reserved    = (pwr_code == 2'b10);

  // R9: pen interrupt only in the powered-down state
  a_r9_pen_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pen_irq_en |-> pwr_down);

  // R8: a running conversion is never powered down
  a_r8_awake_converting: assert property (@(posedge clk) disable iff (!rst_n)
    converting |-> !pwr_down);

  // R10: the reserved code keeps the converter powered
  a_r10_reserved_awake: assert property (@(posedge clk) disable iff (!rst_n)
    pd_reserved |-> !pwr_down);

endmodule

// File: rtl/tsc_serial_frontend.sv
module tsc_serial_frontend
  import tsc_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [RES_W-1:0] adc_data,
  output logic             dout,
  output logic             dout_en,
  output logic             busy,
  output logic [2:0]       chan_sel,
  output logic             ref_single,
  output logic             diff_sw_on,
  output logic             res_short,
  output logic             pwr_down,
  output logic             pen_irq_en,
  output logic             pd_reserved
);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       sclk_q;
  logic       rise, fall;
  logic       cmd_valid;
  ctrl_t      cmd;
  logic       converting;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sclk_q  <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      dout_en <= !cs_n;
    end
  end

  assign rise = !cs_n && sclk && !sclk_q;
  assign fall = !cs_n && !sclk && sclk_q;

  tsc_cmd_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_i),
    .cs_n      (cs_n),
    .rise      (rise),
    .din       (din),
    .cmd_valid (cmd_valid),
    .cmd       (cmd)
  );

  tsc_result_tx #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_i),
    .cs_n       (cs_n),
    .fall       (fall),
    .load       (cmd_valid),
    .short_res  (cmd.short_res),
    .adc_data   (adc_data),
    .busy       (busy),
    .dout       (dout),
    .converting (converting)
  );

  tsc_power_ctl u_pwr (
    .clk         (clk),
    .rst_n       (rst_i),
    .pwr_code    (cmd.pwr_code),
    .converting  (converting),
    .pwr_down    (pwr_down),
    .pen_irq_en  (pen_irq_en),
    .pd_reserved (pd_reserved)
  );

  assign chan_sel   = cmd.chan;
  assign ref_single = cmd.single_ref;
  assign res_short  = cmd.short_res;
  assign diff_sw_on = converting && !cmd.single_ref;

  // R11: switches stay open with a single-ended reference
  a_r11_sw_single_open: assert property (@(posedge clk) disable iff (!rst_i)
    ref_single |-> !diff_sw_on);

  // R12: chip select high releases the data line
  a_r12_oe_off: assert property (@(posedge clk) disable iff (!rst_i)
    cs_n |=> !dout_en);

endmodule

// File: tb/tsc_serial_frontend_test.sv
`timescale 1ns/1ps
module tsc_serial_frontend_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sclk, din;
  logic [11:0] adc_data;
  logic        dout, dout_en, busy, ref_single, diff_sw_on, res_short;
  logic        pwr_down, pen_irq_en, pd_reserved;
  logic [2:0]  chan_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic dout_s [0:63];
  logic busy_s [0:63];
  logic pwr_s  [0:63];
  logic pen_s  [0:63];
  logic sw_s   [0:63];

  always #10 clk = ~clk;

  tsc_serial_frontend uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .adc_data(adc_data), .dout(dout), .dout_en(dout_en), .busy(busy),
    .chan_sel(chan_sel), .ref_single(ref_single), .diff_sw_on(diff_sw_on),
    .res_short(res_short), .pwr_down(pwr_down), .pen_irq_en(pen_irq_en),
    .pd_reserved(pd_reserved)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] put_cmd(input logic [63:0] s, input int off, input logic [7:0] c);
    logic [63:0] r = s;
    for (int k = 0; k < 8; k++) r[off+k] = c[7-k];
    return r;
  endfunction

  // one serial clock per stream bit: low phase (sample at its end), then high phase
  task automatic run_stream(input logic [63:0] bits, input int n,
                            input logic [11:0] adc_b, input int sw_at);
    for (int i = 0; i < n; i++) begin
      if (i == sw_at) adc_data = adc_b;
      din  = bits[i];
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      dout_s[i] = dout; busy_s[i] = busy; pwr_s[i] = pwr_down;
      pen_s[i]  = pen_irq_en; sw_s[i] = diff_sw_on;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    sclk = 1'b0; din = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [11:0] grab(input int first, input int width);
    logic [11:0] w = '0;
    for (int k = 0; k < width; k++) w = {w[10:0], dout_s[first+k]};
    return w;
  endfunction

  task automatic t_reset();
    check("R13 busy", busy, 0);
    check("R13 dout_en", dout_en, 0);
    check("R13 chan_sel", chan_sel, 0);
    check("R13 pwr_down", pwr_down, 1);
    check("R13 pen_irq_en", pen_irq_en, 1);
    check("R13 pd_reserved", pd_reserved, 0);
  endtask

  task automatic t_long_with_lead();
    logic [63:0] s = '0;
    s = put_cmd(s, 3, 8'hB7);             // ch3, 12-bit, single, code 11
    adc_data = 12'hA5C;
    run_stream(s, 27, 12'h000, -1);
    check("R1 no busy before frame", busy_s[10], 0);
    check("R5 busy cycle", busy_s[11], 1);
    check("R5 busy falls", busy_s[12], 0);
    check("R3 12-bit word", grab(12, 12), 12'hA5C);
    check("R3 tail low", {dout_s[24], dout_s[25], dout_s[26]}, 0);
    check("R2 chan", chan_sel, 3);
    check("R2 short", res_short, 0);
    check("R2 single", ref_single, 1);
    check("R8 code11 awake", pwr_down, 0);
    check("R12 dout_en low cs", dout_en, 1);
  endtask

  task automatic t_short_code00();
    logic [63:0] s = '0;
    s = put_cmd(s, 0, 8'hD8);             // ch5, 8-bit, differential, code 00
    adc_data = 12'h3C9;
    run_stream(s, 20, 12'h000, -1);
    check("R5 busy 8-bit", busy_s[8], 1);
    check("R4 8-bit word", grab(9, 8), 12'h03C);
    check("R4 tail low", {dout_s[17], dout_s[18], dout_s[19]}, 0);
    check("R8 awake converting", pwr_s[10], 0);
    check("R9 pen off converting", pen_s[10], 0);
    check("R11 switches on diff", sw_s[10], 1);
    check("R8 down after", pwr_down, 1);
    check("R9 pen on idle 00", pen_irq_en, 1);
    check("R11 switches off idle", diff_sw_on, 0);
    check("R2 chan5 short", {chan_sel, res_short, ref_single}, 5'b10110);
  endtask

  task automatic t_code01();
    logic [63:0] s = '0;
    s = put_cmd(s, 0, 8'h8D);             // ch0, 8-bit, single, code 01
    adc_data = 12'hFFF;
    run_stream(s, 20, 12'h000, -1);
    check("R4 all ones", grab(9, 8), 12'h0FF);
    check("R11 switches single", sw_s[10], 0);
    check("R8 code01 down", pwr_down, 1);
    check("R9 pen off code01", pen_irq_en, 0);
  endtask

  task automatic t_reserved();
    logic [63:0] s = '0;
    s = put_cmd(s, 0, 8'hF6);             // ch7, 12-bit, single, code 10
    adc_data = 12'h123;
    run_stream(s, 24, 12'h000, -1);
    check("R10 word", grab(9, 12), 12'h123);
    check("R10 flag", pd_reserved, 1);
    check("R10 awake", pwr_down, 0);
    check("R9 pen off code10", pen_irq_en, 0);
  endtask

  task automatic t_overlap_long();
    logic [63:0] s = '0;
    s = put_cmd(s, 0, 8'h97);             // ch1
    s = put_cmd(s, 16, 8'hA7);            // ch2, 16 clocks later
    adc_data = 12'h5A3;
    run_stream(s, 40, 12'hC3E, 12);
    check("R6 first word kept", grab(9, 12), 12'h5A3);
    check("R7 second busy", busy_s[24], 1);
    check("R7 second word", grab(25, 12), 12'hC3E);
    check("R7 chan second", chan_sel, 2);
  endtask

  task automatic t_overlap_short();
    logic [63:0] s = '0;
    s = put_cmd(s, 0, 8'h9F);
    s = put_cmd(s, 12, 8'hBF);            // 12 clocks later
    adc_data = 12'h812;
    run_stream(s, 32, 12'h7E4, 10);
    check("R7 short first", grab(9, 8), 12'h081);
    check("R7 short gap low", {dout_s[17], dout_s[18], dout_s[19]}, 0);
    check("R7 short second busy", busy_s[20], 1);
    check("R7 short second", grab(21, 8), 12'h07E);
  endtask

  task automatic t_cs_abort();
    logic [63:0] s = '0;
    s[0] = 1; s[1] = 1; s[2] = 0; s[3] = 1;   // partial word
    run_stream(s, 4, 12'h000, -1);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 dout_en off", dout_en, 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    s = put_cmd('0, 0, 8'hC7);            // ch4, 12-bit
    adc_data = 12'h0F0;
    run_stream(s, 24, 12'h000, -1);
    check("R12 fresh frame word", grab(9, 12), 12'h0F0);
    check("R12 fresh frame chan", chan_sel, 4);
    s = put_cmd('0, 0, 8'h84);            // ch0, 12-bit, code 00
    run_stream(s, 9, 12'h000, -1);
    check("R12 busy seen", busy_s[8], 1);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 busy cleared", busy, 0);
    check("R12 oe cleared", dout_en, 0);
    check("R12 down after abort", pwr_down, 1);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; adc_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    t_long_with_lead();
    t_short_code00();
    t_code01();
    t_reserved();
    t_overlap_long();
    t_overlap_short();
    t_cs_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule